// File: doc/BRIEF.md
# Stack Pointer Call/Return Sequencer

This block owns a processor's 16-bit stack pointer. It turns stack commands into byte-wide memory transfers. A command is one of the following: load the pointer, push a register pair, pop a register pair, call, return, or a conditional form of call or return. The block breaks each pair into two byte transfers on a memory request port. The stack grows toward lower addresses. On a push, the pointer moves down before each store, and the high byte is stored first. On a pop, each load happens before the pointer moves up, and the low byte is read first. The pointer therefore always addresses the most recently stored byte.

A call stores the return address on the stack, one byte at a time, and then publishes the target as the new program counter. A return pulls two bytes from the stack and publishes them as the new program counter. Pair values such as the accumulator-and-flags word are supplied and collected by the surrounding datapath, which also evaluates the condition of the conditional forms and presents it as `cmd_cond`.

The command port and the memory request port both use a valid/ready handshake. A command transfers on a clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is low for as long as the block is busy. A memory request transfers on an edge where both `mem_req_valid` and `mem_req_ready` are high. While `mem_req_ready` is low, the block holds the request unchanged, so the memory can stall it for any number of cycles. Read data returns on `mem_rsp_valid`, at any number of cycles after the read request is accepted. Only one read is outstanding at a time, so the responses need no tag.

Top module: `stack_call_unit`

## Requirements
- R1: During and after reset, `sp` is the parameter `RESET_SP`, `busy` is 0, `cmd_ready` is 1, and no memory request is valid.
- R2: Push (op code 1) writes the high byte of `cmd_value` to address sp-1, then writes the low byte to address sp-2, and leaves `sp` lowered by 2.
- R3: Pop (op code 2) reads the byte at sp as the low byte and the byte at sp+1 as the high byte. It leaves `sp` raised by 2. It then presents the 16-bit result on `pop_data` with a one-cycle `pop_valid` pulse.
- R4: Load (op code 0) sets `sp` to `cmd_value` in the cycle after acceptance. It makes no memory request, and `busy` stays 0.
- R5: Call (op code 3) stores `cmd_link` with the same byte order as a push. It then pulses `pc_we` for one cycle with `pc_value` equal to `cmd_value`.
- R6: Return (op code 4) reads two bytes with the same order as a pop. It then pulses `pc_we` for one cycle with `pc_value` equal to the popped word.
- R7: Conditional call (op code 5) and conditional return (op code 6) behave exactly like codes 3 and 4 when `cmd_cond` is 1. When `cmd_cond` is 0, the command is accepted and has no effect on memory, `sp`, `pc_we`, `pop_valid` or `busy`. Op code 7 is accepted and ignored in the same way.
- R8: `sp` arithmetic wraps modulo 65536 in both directions: below 0x0000 comes 0xFFFF, and above 0xFFFF comes 0x0000.
- R9: `busy` rises in the cycle after a memory-using command is accepted and stays high until its last byte transfer completes. `cmd_ready` is low throughout that time. The `pc_we` or `pop_valid` pulse appears in the first cycle with `busy` low.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request's address, direction and data are held. Each read waits for `mem_rsp_valid` before the next request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (block idle) |
| cmd_op | input | 3 | Op code: 0 load, 1 push, 2 pop, 3 call, 4 return, 5 call-if, 6 return-if, 7 none |
| cmd_value | input | 16 | Pair to push, new pointer, or call target |
| cmd_link | input | 16 | Return address stored by a call |
| cmd_cond | input | 1 | Condition result for op codes 5 and 6 |
| mem_req_valid | output | 1 | Byte request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | 16 | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Read byte returned |
| mem_rsp_rdata | input | 8 | Returned byte |
| pop_valid | output | 1 | One-cycle pulse: pop result available |
| pop_data | output | 16 | Popped pair |
| pc_we | output | 1 | One-cycle pulse: load program counter |
| pc_value | output | 16 | New program counter |
| sp | output | 16 | Current stack pointer |
| busy | output | 1 | A command is moving bytes |

## Verification
The bench uses the defaults: `BYTE_W` of 8, and `RESET_SP` of 0x0000. With a reset pointer of zero, the very first push after reset already crosses the bottom of the address space, so the downward wrap is exercised without a load. Loading the pointer with 0x0001 before a push-and-pop round trip then exercises the pop that crosses the top of the space. A memory model that deasserts ready on every other cycle, and answers reads a cycle late, exercises the request hold and the single-outstanding-read rule.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_LDSP  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_CALL  = 3'd3,
    OP_RET   = 3'd4,
    OP_CALLC = 3'd5,
    OP_RETC  = 3'd6,
    OP_NONE  = 3'd7
  } stk_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR_HI,
    S_WR_LO,
    S_RD_LO,
    S_WT_LO,
    S_RD_HI,
    S_WT_HI
  } stk_state_e;

  typedef enum logic [1:0] {
    K_PUSH,
    K_POP,
    K_CALL,
    K_RET
  } stk_kind_e;

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int                 AW       = 16,
  parameter logic [AW-1:0]      RESET_SP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          dec,
  input  logic          inc,
  output logic [AW-1:0] sp
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] sp_q;

  // Load has priority; dec and inc come from exclusive sequencer states.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp_q <= RESET_SP;
    else if (ld)   sp_q <= ld_val;
    else if (dec)  sp_q <= sp_q - ONE;
    else if (inc)  sp_q <= sp_q + ONE;
  end

  assign sp = sp_q;

  // R4: a load lands exactly one cycle later
  p_sp_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (sp == $past(ld_val)));

  // R8: without a load the pointer moves at most one step, modulo 2^AW
  p_sp_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> (sp == $past(sp) || sp == $past(sp) + ONE || sp == $past(sp) - ONE));

endmodule

// File: rtl/stk_gather.sv
module stk_gather #(
  parameter int DW    = 8,
  parameter int LANES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    cap,
  input  logic [DW-1:0]       din,
  output logic [LANES*DW-1:0] word
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [DW-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lane_q <= '0;
      else if (cap[i]) lane_q <= din;
    end
    assign word[i*DW +: DW] = lane_q;
  end

  // R10: the sequencer captures one byte lane per response
  p_one_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap));

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [2*DW-1:0] cmd_value,
  input  logic [2*DW-1:0] cmd_link,
  input  logic            cmd_cond,
  input  logic [2*DW-1:0] sp,
  output logic            sp_ld,
  output logic            sp_dec,
  output logic            sp_inc,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [2*DW-1:0] mem_req_addr,
  output logic [DW-1:0]   mem_req_wdata,
  input  logic            mem_rsp_valid,
  output logic [1:0]      cap,
  input  logic [2*DW-1:0] pair,
  output logic            pop_valid,
  output logic            pc_we,
  output logic [2*DW-1:0] pc_value,
  output logic            busy
);

  localparam int            AW  = 2 * DW;
  localparam logic [AW-1:0] ONE = AW'(1);

  stk_state_e    state_q, state_d;
  stk_kind_e     kind_q, kind_d;
  logic [AW-1:0] wbuf_q, wbuf_d;
  logic [AW-1:0] tgt_q, tgt_d;
  logic          done_q, done_d;

  stk_op_e op;
  logic    cmd_fire;
  logic    req_fire;
  logic    is_wr_state;
  logic    is_rd_state;

  assign op          = stk_op_e'(cmd_op);
  assign cmd_ready   = (state_q == S_IDLE);
  assign cmd_fire    = cmd_valid && cmd_ready;
  assign is_wr_state = (state_q == S_WR_HI) || (state_q == S_WR_LO);
  assign is_rd_state = (state_q == S_RD_LO) || (state_q == S_RD_HI);
  assign req_fire    = mem_req_valid && mem_req_ready;

  // Memory request: stores go one below the pointer, loads at the pointer.
  assign mem_req_valid = is_wr_state || is_rd_state;
  assign mem_req_write = is_wr_state;
  assign mem_req_addr  = is_wr_state ? (sp - ONE) : sp;
  assign mem_req_wdata = (state_q == S_WR_HI) ? wbuf_q[AW-1:DW] : wbuf_q[DW-1:0];

  // Pointer control
  assign sp_ld  = cmd_fire && (op == OP_LDSP);
  assign sp_dec = req_fire && is_wr_state;
  assign sp_inc = req_fire && is_rd_state;

  // Byte capture: low lane first, then high lane
  assign cap[0] = (state_q == S_WT_LO) && mem_rsp_valid;
  assign cap[1] = (state_q == S_WT_HI) && mem_rsp_valid;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    wbuf_d  = wbuf_q;
    tgt_d   = tgt_q;
    done_d  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (cmd_fire) begin
          unique case (op)
            OP_PUSH: begin
              kind_d  = K_PUSH;
              wbuf_d  = cmd_value;
              state_d = S_WR_HI;
            end
            OP_POP: begin
              kind_d  = K_POP;
              state_d = S_RD_LO;
            end
            OP_CALL, OP_CALLC: begin
              if (op == OP_CALL || cmd_cond) begin
                kind_d  = K_CALL;
                wbuf_d  = cmd_link;
                tgt_d   = cmd_value;
                state_d = S_WR_HI;
              end
            end
            OP_RET, OP_RETC: begin
              if (op == OP_RET || cmd_cond) begin
                kind_d  = K_RET;
                state_d = S_RD_LO;
              end
            end
            default: ;
          endcase
        end
      end
      S_WR_HI: if (req_fire) state_d = S_WR_LO;
      S_WR_LO: begin
        if (req_fire) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end
      end
      S_RD_LO: if (req_fire) state_d = S_WT_LO;
      S_WT_LO: if (mem_rsp_valid) state_d = S_RD_HI;
      S_RD_HI: if (req_fire) state_d = S_WT_HI;
      S_WT_HI: begin
        if (mem_rsp_valid) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= K_PUSH;
      wbuf_q  <= '0;
      tgt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      wbuf_q  <= wbuf_d;
      tgt_q   <= tgt_d;
      done_q  <= done_d;
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign pop_valid = done_q && (kind_q == K_POP);
  assign pc_we     = done_q && ((kind_q == K_CALL) || (kind_q == K_RET));
  assign pc_value  = (kind_q == K_CALL) ? tgt_q : pair;

  // R2: every accepted store leaves the pointer on the stored byte
  p_wr_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && mem_req_write) |=> (sp == $past(mem_req_addr)));

  // R3: every accepted load moves the pointer one past the loaded byte
  p_rd_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !mem_req_write) |=> (sp == $past(mem_req_addr) + ONE));

  // R10: a stalled request is held unchanged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
       && $stable(mem_req_wdata)));

  // R9: result pulses only follow a busy period
  p_pulse_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we || pop_valid) |-> ($past(busy) && !busy));

  // R7: a false condition never starts a transfer
  p_cond_false_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !cmd_cond && (op == OP_CALLC || op == OP_RETC)) |=> !busy);

endmodule

// File: rtl/stack_call_unit.sv
module stack_call_unit #(
  parameter int                  BYTE_W   = 8,
  parameter logic [2*BYTE_W-1:0] RESET_SP = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [2:0]          cmd_op,
  input  logic [2*BYTE_W-1:0] cmd_value,
  input  logic [2*BYTE_W-1:0] cmd_link,
  input  logic                cmd_cond,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [2*BYTE_W-1:0] mem_req_addr,
  output logic [BYTE_W-1:0]   mem_req_wdata,
  input  logic                mem_rsp_valid,
  input  logic [BYTE_W-1:0]   mem_rsp_rdata,
  output logic                pop_valid,
  output logic [2*BYTE_W-1:0] pop_data,
  output logic                pc_we,
  output logic [2*BYTE_W-1:0] pc_value,
  output logic [2*BYTE_W-1:0] sp,
  output logic                busy
);

  localparam int AW = 2 * BYTE_W;

  logic          sp_ld, sp_dec, sp_inc;
  logic [1:0]    cap;
  logic [AW-1:0] pair;

  stk_ptr #(.AW(AW), .RESET_SP(RESET_SP)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (sp_ld),
    .ld_val (cmd_value),
    .dec    (sp_dec),
    .inc    (sp_inc),
    .sp     (sp)
  );

  stk_gather #(.DW(BYTE_W), .LANES(2)) u_gather (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (cap),
    .din   (mem_rsp_rdata),
    .word  (pair)
  );

  stk_seq #(.DW(BYTE_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_op        (cmd_op),
    .cmd_value     (cmd_value),
    .cmd_link      (cmd_link),
    .cmd_cond      (cmd_cond),
    .sp            (sp),
    .sp_ld         (sp_ld),
    .sp_dec        (sp_dec),
    .sp_inc        (sp_inc),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .cap           (cap),
    .pair          (pair),
    .pop_valid     (pop_valid),
    .pc_we         (pc_we),
    .pc_value      (pc_value),
    .busy          (busy)
  );

  assign pop_data = pair;

  // R1: nothing is requested while held in reset
  p_quiet_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (!mem_req_valid && !busy));

endmodule

// File: tb/tb_stack_call_unit.sv
module tb_stack_call_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd7;
  logic [15:0] cmd_value = '0;
  logic [15:0] cmd_link = '0;
  logic        cmd_cond = 1'b0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready;
  logic [15:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid;
  logic [7:0]  mem_rsp_rdata;
  logic        pop_valid, pc_we, busy;
  logic [15:0] pop_data, pc_value, sp;

  always #10 clk = ~clk;

  stack_call_unit dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_value(cmd_value), .cmd_link(cmd_link), .cmd_cond(cmd_cond),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .pop_valid(pop_valid), .pop_data(pop_data),
    .pc_we(pc_we), .pc_value(pc_value), .sp(sp), .busy(busy)
  );

  // Memory model: 256 bytes indexed by the low address byte
  logic        stall_en = 1'b0;
  logic [7:0]  mem [0:255];
  logic [15:0] wl_addr [0:15];
  logic [7:0]  wl_data [0:15];
  logic [15:0] rl_addr [0:15];
  int          wr_cnt = 0;
  int          rd_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b1;
      mem_rsp_valid <= 1'b0;
      mem_rsp_rdata <= '0;
    end else begin
      mem_req_ready <= stall_en ? ~mem_req_ready : 1'b1;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mem[mem_req_addr[7:0]]  <= mem_req_wdata;
          wl_addr[wr_cnt & 15]    <= mem_req_addr;
          wl_data[wr_cnt & 15]    <= mem_req_wdata;
          wr_cnt                  <= wr_cnt + 1;
        end else begin
          mem_rsp_valid           <= 1'b1;
          mem_rsp_rdata           <= mem[mem_req_addr[7:0]];
          rl_addr[rd_cnt & 15]    <= mem_req_addr;
          rd_cnt                  <= rd_cnt + 1;
        end
      end
    end
  end

  // Output monitor, sampled away from the active edge
  int          pcwe_cnt = 0;
  int          popv_cnt = 0;
  logic [15:0] last_pc  = '0;
  logic [15:0] last_pop = '0;
  logic        pulse_busy_bad = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pc_we)     begin pcwe_cnt = pcwe_cnt + 1; last_pc  = pc_value; end
      if (pop_valid) begin popv_cnt = popv_cnt + 1; last_pop = pop_data; end
      if ((pc_we || pop_valid) && busy) pulse_busy_bad = 1'b1;
    end
  end

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic after_busy, after_rdy;

  task automatic send(input logic [2:0] op, input logic [15:0] val,
                      input logic [15:0] link, input logic cond);
    @(negedge clk);
    cmd_op = op; cmd_value = val; cmd_link = link; cmd_cond = cond;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid  = 1'b0;
    after_busy = busy;
    after_rdy  = cmd_ready;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(sp == 16'h0000, "R1 sp", 32'(sp), 32'h0);
    chk(!busy && cmd_ready, "R1 idle", 32'({busy, cmd_ready}), 32'h1);
    chk(!mem_req_valid, "R1 no request", 32'(mem_req_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sp == 16'h0000 && !busy, "R1 after release", 32'(sp), 32'h0);
  endtask

  task automatic t_push_wrap;
    int b = wr_cnt;
    send(3'd1, 16'hA1B2, 16'h0, 1'b0);
    chk(after_busy && !after_rdy, "R9 busy blocks ready", 32'({after_busy, after_rdy}), 32'h2);
    chk(wr_cnt == b + 2, "R2 two writes", 32'(wr_cnt - b), 32'd2);
    chk(wl_addr[b & 15] == 16'hFFFF && wl_data[b & 15] == 8'hA1, "R2 R8 high first",
        {wl_addr[b & 15], 8'h0, wl_data[b & 15]}, 32'hFFFF00A1);
    chk(wl_addr[(b+1) & 15] == 16'hFFFE && wl_data[(b+1) & 15] == 8'hB2, "R2 low second",
        {wl_addr[(b+1) & 15], 8'h0, wl_data[(b+1) & 15]}, 32'hFFFE00B2);
    chk(sp == 16'hFFFE, "R2 R8 sp after push", 32'(sp), 32'hFFFE);
  endtask

  task automatic t_pop;
    int r = rd_cnt;
    int p = popv_cnt;
    send(3'd2, 16'h0, 16'h0, 1'b0);
    chk(rl_addr[r & 15] == 16'hFFFE && rl_addr[(r+1) & 15] == 16'hFFFF, "R3 read order",
        {rl_addr[r & 15], rl_addr[(r+1) & 15]}, 32'hFFFEFFFF);
    chk(popv_cnt == p + 1 && last_pop == 16'hA1B2, "R3 pop data", 32'(last_pop), 32'hA1B2);
    chk(sp == 16'h0000, "R3 R8 sp after pop", 32'(sp), 32'h0);
  endtask

  task automatic t_load;
    int b = wr_cnt + rd_cnt;
    send(3'd0, 16'h0100, 16'h0, 1'b0);
    chk(sp == 16'h0100, "R4 load", 32'(sp), 32'h0100);
    chk(wr_cnt + rd_cnt == b && !after_busy, "R4 no traffic", 32'(wr_cnt + rd_cnt - b), 32'h0);
  endtask

  task automatic t_call_ret;
    int b = wr_cnt;
    int q = pcwe_cnt;
    send(3'd3, 16'h2345, 16'h1003, 1'b0);
    chk(wl_addr[b & 15] == 16'h00FF && wl_data[b & 15] == 8'h10 &&
        wl_data[(b+1) & 15] == 8'h03, "R5 link stored",
        {wl_addr[b & 15], wl_data[b & 15], wl_data[(b+1) & 15]}, 32'h00FF1003);
    chk(pcwe_cnt == q + 1 && last_pc == 16'h2345, "R5 target", 32'(last_pc), 32'h2345);
    chk(sp == 16'h00FE, "R5 sp", 32'(sp), 32'h00FE);
    send(3'd4, 16'h0, 16'h0, 1'b0);
    chk(pcwe_cnt == q + 2 && last_pc == 16'h1003, "R6 return pc", 32'(last_pc), 32'h1003);
    chk(sp == 16'h0100, "R6 sp", 32'(sp), 32'h0100);
  endtask

  task automatic t_cond;
    int b = wr_cnt + rd_cnt;
    int q = pcwe_cnt;
    send(3'd5, 16'h7777, 16'h5555, 1'b0);
    chk(!after_busy && wr_cnt + rd_cnt == b && pcwe_cnt == q && sp == 16'h0100,
        "R7 call-if false", 32'(sp), 32'h0100);
    send(3'd6, 16'h0, 16'h0, 1'b0);
    chk(!after_busy && wr_cnt + rd_cnt == b && pcwe_cnt == q && sp == 16'h0100,
        "R7 return-if false", 32'(sp), 32'h0100);
    send(3'd7, 16'h0, 16'h0, 1'b1);
    chk(!after_busy && wr_cnt + rd_cnt == b && sp == 16'h0100, "R7 op 7 ignored",
        32'(wr_cnt + rd_cnt - b), 32'h0);
    send(3'd5, 16'h4000, 16'hBEEF, 1'b1);
    chk(last_pc == 16'h4000 && sp == 16'h00FE, "R7 call-if true", 32'(last_pc), 32'h4000);
    send(3'd6, 16'h0, 16'h0, 1'b1);
    chk(last_pc == 16'hBEEF && sp == 16'h0100, "R7 return-if true", 32'(last_pc), 32'hBEEF);
  endtask

  task automatic t_stall_wrap;
    int p = popv_cnt;
    stall_en = 1'b1;
    send(3'd0, 16'h0001, 16'h0, 1'b0);
    send(3'd1, 16'h5A77, 16'h0, 1'b0);
    chk(sp == 16'hFFFF, "R8 R10 push across zero", 32'(sp), 32'hFFFF);
    send(3'd2, 16'h0, 16'h0, 1'b0);
    chk(popv_cnt == p + 1 && last_pop == 16'h5A77, "R10 stalled pop data",
        32'(last_pop), 32'h5A77);
    chk(sp == 16'h0001, "R8 pop across top", 32'(sp), 32'h0001);
    stall_en = 1'b0;
    chk(!pulse_busy_bad, "R9 pulses only when idle", 32'(pulse_busy_bad), 32'h0);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_push_wrap();
    t_pop();
    t_load();
    t_call_ret();
    t_cond();
    t_stall_wrap();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule